// File: doc/BRIEF.md
# Bus-Idle Sleep Mode Controller

This block decides when a low-power measurement device stops all of its activity and when it resumes. It has two independent ways in. The first is a timeout. A counter advances on a slow time-base strobe while both serial bus lines are seen low, and it clears the moment either line is high. When it reaches its terminal count, the device falls asleep. The second is a sleep control bit that software sets over the bus. While that bit is high the device is asleep, whatever the bus lines are doing.

Each entry has its own exit rule. After a timeout entry, the first rising edge on either bus line wakes the device on the next clock. After a software entry, bus edges and time-base strobes have no effect, and only clearing the bit, or a reset, brings the device back. The controller remembers which way it went to sleep so that it applies the right exit rule.

While the device is asleep, the halt output freezes the measurement and estimation logic, so that work continues from where it stopped. On every exit from sleep, a one-cycle resume strobe restarts the voltage averaging period, so the first new reading arrives one full period after wake-up. With the default terminal count of 65536 strobes at 32 kHz, the timeout is about 2.0 s.

Top module: `bus_idle_sleep_ctl`

## Requirements
- R1: After reset, `sleep_o`, `halt_o` and `resume_o` are all 0.
- R2: With both lines low and the software bit low, sleep begins in the cycle after the TIMEOUT_TICKS-th consecutive `tick_i` strobe, and not after TIMEOUT_TICKS-1 strobes.
- R3: Any clock in which `scl_i` or `sda_i` is 1 while awake clears the idle count, so that a further full TIMEOUT_TICKS strobes are needed.
- R4: In timeout sleep, a 0-to-1 change on `scl_i` or on `sda_i` sets `sleep_o` to 0 in the next cycle.
- R5: When `sw_sleep_i` is 1, `sleep_o` is 1 from the next cycle on, whether the device was awake or already in timeout sleep.
- R6: While in software sleep, rising edges on the bus lines and `tick_i` strobes leave `sleep_o` at 1.
- R7: When `sw_sleep_i` returns to 0 during software sleep, `sleep_o` goes to 0 in the next cycle, even if both lines are low.
- R8: `halt_o` is 1 in exactly the cycles in which `sleep_o` is 1.
- R9: `resume_o` is 1 for exactly one cycle, the first awake cycle after any sleep period, and is 0 at all other times.
- R10: After any wake-up, the idle count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on reset) |
| scl_i | input | 1 | Synchronised serial clock line level |
| sda_i | input | 1 | Synchronised serial data line level |
| sw_sleep_i | input | 1 | Software sleep control bit, 1 = sleep |
| tick_i | input | 1 | One-cycle strobe from the 32 kHz time base |
| sleep_o | output | 1 | Device is asleep |
| halt_o | output | 1 | Freeze enable for measurement and estimation state |
| resume_o | output | 1 | One-cycle strobe on wake-up that restarts voltage averaging |

## Verification
The assertions take for granted that `scl_i` and `sda_i` are already synchronised to `clk`. They also assume that `tick_i` is a single-cycle strobe and that `sw_sleep_i` is a register level that holds between changes. The stimulus changes every input only on the falling clock edge and raises `tick_i` for one cycle at a time. It uses a terminal count of 8 so that every position of a line glitch within the idle window can be swept. Wake-ups alternate between the two lines, and both entry paths are covered, including a software entry made while the device is already in timeout sleep.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE     = 2'd0,
        ST_BUS_SLEEP = 2'd1,
        ST_SW_SLEEP  = 2'd2
    } sleep_st_e;

    typedef struct packed {
        sleep_st_e st;
        logic      resume;
    } ctl_regs_t;

endpackage

// File: rtl/sleep_line_mon.sv
module sleep_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic both_low_o,
    output logic any_rise_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_i;
        prev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // Idle-high reset value: no false edge right after reset.
    assign both_low_o = !scl_i && !sda_i;
    assign any_rise_o = (scl_i && !prev_q.scl) || (sda_i && !prev_q.sda);
endmodule

// File: rtl/sleep_idle_timer.sv
module sleep_idle_timer #(
    parameter int TIMEOUT_TICKS = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic both_low_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             armed;

    always_comb begin
        armed    = run_i && both_low_i;
        expire_o = armed && tick_i && (cnt_q == LAST);
        cnt_d    = cnt_q;
        if (!armed)        cnt_d = '0;
        else if (expire_o) cnt_d = '0;
        else if (tick_i)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bus_idle_sleep_ctl.sv
module bus_idle_sleep_ctl
    import sleep_ctl_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic sw_sleep_i,
    input  logic tick_i,
    output logic sleep_o,
    output logic halt_o,
    output logic resume_o
);
    ctl_regs_t r_d, r_q;
    logic both_low, any_rise, expire;

    sleep_line_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .both_low_o (both_low),
        .any_rise_o (any_rise)
    );

    sleep_idle_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (r_q.st == ST_AWAKE),
        .both_low_i (both_low),
        .tick_i     (tick_i),
        .expire_o   (expire)
    );

    always_comb begin
        r_d        = r_q;
        r_d.resume = 1'b0;
        unique case (r_q.st)
            ST_AWAKE: begin
                if (sw_sleep_i)  r_d.st = ST_SW_SLEEP;
                else if (expire) r_d.st = ST_BUS_SLEEP;
            end
            ST_BUS_SLEEP: begin
                if (sw_sleep_i) begin
                    r_d.st = ST_SW_SLEEP;
                end else if (any_rise) begin
                    r_d.st     = ST_AWAKE;
                    r_d.resume = 1'b1;
                end
            end
            ST_SW_SLEEP: begin
                if (!sw_sleep_i) begin
                    r_d.st     = ST_AWAKE;
                    r_d.resume = 1'b1;
                end
            end
            default: r_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_AWAKE, resume: 1'b0};
        else        r_q <= r_d;
    end

    assign sleep_o  = (r_q.st != ST_AWAKE);
    assign halt_o   = (r_q.st != ST_AWAKE);
    assign resume_o = r_q.resume;
endmodule

// File: rtl/bus_idle_sleep_ctl_chk.sv
module bus_idle_sleep_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sw_sleep_i,
    input logic tick_i,
    input logic sleep_o,
    input logic halt_o,
    input logic resume_o
);
    // R2: sleep only starts from the bit or from an idle strobe with both lines low
    a_r2_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> ($past(sw_sleep_i) || ($past(tick_i) && !$past(scl_i) && !$past(sda_i))));

    a_r5_sw_enter: assert property (@(posedge clk) disable iff (!rst_n)
        sw_sleep_i |=> sleep_o);

    a_r6_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && sw_sleep_i) |=> sleep_o);

    a_r7_sw_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_sleep_i) && sleep_o) |=> !sleep_o);

    a_r8_halt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> halt_o);

    a_r9_resume_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> resume_o);

    a_r9_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);

    a_r9_resume_awake: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> !sleep_o);
endmodule

bind bus_idle_sleep_ctl bus_idle_sleep_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sw_sleep_i (sw_sleep_i),
    .tick_i     (tick_i),
    .sleep_o    (sleep_o),
    .halt_o     (halt_o),
    .resume_o   (resume_o)
);

// File: tb/bus_idle_sleep_ctl_tb.sv
module bus_idle_sleep_ctl_tb;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, sw = 1'b0, tick = 1'b0;
    logic sleep_w, halt_w, resume_w;
    int   nvec = 0, nerr = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    bus_idle_sleep_ctl #(.TIMEOUT_TICKS(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sw_sleep_i(sw), .tick_i(tick),
        .sleep_o(sleep_w), .halt_o(halt_w), .resume_o(resume_w)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); tick = 1'b0; step();
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // sleep and halt together (R8)
    task automatic chk_sleep(input string req, input logic exp);
        chk(req, sleep_w, exp);
        chk("R8 halt", halt_w, exp);
    endtask

    task automatic wake_by(input bit use_sda, input string req);
        if (use_sda) sda = 1'b1; else scl = 1'b1;
        step();
        chk_sleep(req, 1'b0);
        chk("R9 resume set", resume_w, 1'b1);
        step();
        chk("R9 resume drop", resume_w, 1'b0);
        scl = 1'b0; sda = 1'b0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        chk_sleep("R1 reset sleep", 1'b0);
        chk("R1 reset resume", resume_w, 1'b0);

        // lines high: ticks alone never cause sleep (R3)
        ticks(2 * T);
        chk_sleep("R3 lines high", 1'b0);

        // sweep glitch position k inside the idle window
        scl = 1'b0; sda = 1'b0; step();
        for (int k = 0; k < T; k++) begin
            ticks(k);
            chk_sleep("R2 partial", 1'b0);
            if (k[0]) sda = 1'b1; else scl = 1'b1;
            step();
            scl = 1'b0; sda = 1'b0;
            step();
            chk_sleep("R3 glitch", 1'b0);
            ticks(T - 1);
            chk_sleep("R3 restart", 1'b0);
            ticks(1);
            chk_sleep("R2 expire", 1'b1);
            chk("R9 no resume in sleep", resume_w, 1'b0);
            wake_by(k[0], "R4 bus wake");
            // fresh count after wake (R10)
            ticks(T - 1);
            chk_sleep("R10 fresh count", 1'b0);
            scl = 1'b1; step(); scl = 1'b0; step();
        end

        // software sleep from awake, bus edges and ticks ignored
        sw = 1'b1; step();
        chk_sleep("R5 sw enter", 1'b1);
        for (int j = 0; j < 4; j++) begin
            scl = 1'b1; step(); sda = 1'b1; step();
            chk_sleep("R6 edges ignored", 1'b1);
            scl = 1'b0; sda = 1'b0; step();
            ticks(T);
            chk_sleep("R6 ticks ignored", 1'b1);
        end
        sw = 1'b0; step();
        chk_sleep("R7 sw exit", 1'b0);
        chk("R9 resume sw", resume_w, 1'b1);
        step();
        chk("R9 resume drop sw", resume_w, 1'b0);
        ticks(T - 1);
        chk_sleep("R10 after sw wake", 1'b0);
        ticks(1);
        chk_sleep("R2 after sw wake", 1'b1);

        // software bit while already in timeout sleep
        sw = 1'b1; step();
        chk_sleep("R5 sw over bus sleep", 1'b1);
        scl = 1'b1; step();
        chk_sleep("R6 bus edge after sw", 1'b1);
        scl = 1'b0; step();
        sw = 1'b0; step();
        chk_sleep("R7 exit lines low", 1'b0);
        chk("R9 resume", resume_w, 1'b1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule